// File: doc/BRIEF.md
# Long-Press Push-Button Reset Controller

This block turns one or two active-low push-button lines into an active-low reset request. The request fires only after every monitored button has been held down at the same time for a long hold time. Shorter presses produce nothing, so a quick tap of the same keys can still serve as an ordinary user input elsewhere in the system. A static select line chooses one of two hold times. A build parameter chooses how the request ends. In level mode it ends when a button is let go. In pulse mode it lasts a fixed time.

All times are counted in ticks from an internal prescaler, so a simulation can use short times and silicon can use seconds. The button and select lines pass through two-flop synchronisers. After power-on reset the block waits out a short start-up delay before it arms. Buttons that are already held when power comes up then give a request once the start-up delay and the hold time have both passed. Only one request is made per press. At least one button must be released before the block arms again.

Top module: `hold_reset_ctrl`

## Requirements
- R1: With `dly_sel` low, `rst_req_n` falls only after all enabled `btn_n` bits have been low together for HOLD_A_TICKS ticks. Measured from the clock edge after the press is driven, the fall comes no sooner than (HOLD_A_TICKS-1)·TICK_DIV clocks and no later than HOLD_A_TICKS·TICK_DIV+6 clocks.
- R2: Any enabled button going high before the hold completes restarts the measurement. The timing window of R1 then counts from the renewed press.
- R3: The captured select chooses the hold: 0 selects HOLD_A_TICKS and 1 selects HOLD_B_TICKS. A press shorter than the selected hold produces no request.
- R4: The select is captured during start-up and in every cycle in which at least one button is high. A change on `dly_sel` while all buttons are held low has no effect on the hold in progress.
- R5: In pulse mode (LEVEL_MODE=0) the request stays low for PULSE_TICKS ticks whatever the buttons do, that is for (PULSE_TICKS-1)·TICK_DIV to PULSE_TICKS·TICK_DIV+2 clocks. A high-then-low glitch on a button during the pulse is not recognised.
- R6: In level mode (LEVEL_MODE=1) the request stays low while all buttons remain held. It returns high within 5 clocks after any button goes high.
- R7: Exactly one request is made per press. While the buttons stay held after a request, no further request is made.
- R8: In pulse mode, a button that is released during the pulse and stays high is acted on once the pulse ends. It re-arms the block, so the next full hold gives a new request.
- R9: With a selected hold of zero ticks, the request falls within 5 clocks of all buttons going low.
- R10: `rst_req_n` is high during and after power-on reset, and for at least START_TICKS ticks afterwards. If the buttons are held low through power-up, the request falls after start-up plus hold, that is between (START_TICKS+HOLD-2)·TICK_DIV and (START_TICKS+HOLD)·TICK_DIV+6 clocks after reset is released.
- R11: With NUM_BTN=2, holding only one button low never produces a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| btn_n | input | NUM_BTN | Push-button lines, low while pressed, asynchronous |
| dly_sel | input | 1 | Hold-time select (0: HOLD_A_TICKS, 1: HOLD_B_TICKS), static in normal use |
| rst_req_n | output | 1 | Reset request, low while asserted |

## Verification
The hardest states to reach from the ports are the ones after a pulse has already been given. Examples are a glitch during the pulse that must not re-arm the block, and a release during the pulse that must re-arm it once the pulse ends. The stimulus waits for the request to fall, counts clocks into the pulse, and then toggles or releases a button at a known point. It then counts falling edges of the request over a long further hold. Select changes during a hold are made in the same way, a few clocks after the press has passed the synchroniser. A second instance in level mode, with a zero hold on the other select value, shows whether the late select value was taken.

// File: rtl/hrc_pkg.sv
// Shared types and helpers for the long-press reset controller.
// Assumes: nothing beyond IEEE 1800-2017.
package hrc_pkg;

    // Controller phases: start-up wait, armed, request active, waiting for a release.
    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRE  = 2'd2,
        ST_WAIT  = 2'd3
    } hrc_state_e;

    // Largest of four non-negative values, used to size the shared counter.
    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/hrc_sync.sv
// Two-flop synchroniser for a bus of independent asynchronous lines.
// Assumes: each bit is a slow level (button or strap), so bits need no mutual coherence.
module hrc_sync #(
    parameter int             W       = 3,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] meta_q;

    // Two register stages, both loaded with the idle value during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end

endmodule

// File: rtl/hrc_tick.sv
// Prescaler giving a one-clock tick every DIV clocks; all delays count these ticks.
// Assumes: DIV >= 1; with DIV = 1 the tick is permanently high.
module hrc_tick #(
    parameter int DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (DIV == 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(DIV);
            localparam logic [DW-1:0] LAST = DW'(DIV - 1);
            logic [DW-1:0] div_q;

            // Free-running divider that wraps after DIV clocks.
            always_ff @(posedge clk) begin
                if (!rst_n) div_q <= '0;
                else if (div_q == LAST) div_q <= '0;
                else div_q <= div_q + 1'b1;
            end

            assign tick = (div_q == LAST);

            a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/hrc_ctrl.sv
// Hold / pulse sequencer. It counts ticks while all buttons are held, raises one
// request per press, and ends it either on release (level) or after a fixed pulse.
// Assumes: btn_s and sel_s are already synchronised; PULSE_TICKS >= 1, START_TICKS >= 1.
module hrc_ctrl
    import hrc_pkg::*;
#(
    parameter int NUM_BTN     = 2,
    parameter int HOLD_A      = 7500,
    parameter int HOLD_B      = 12500,
    parameter int PULSE_TICKS = 400,
    parameter int START_TICKS = 1,
    parameter int LEVEL_MODE  = 0,
    parameter int CW          = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [NUM_BTN-1:0] btn_s,
    input  logic               sel_s,
    output logic               req_n
);

    localparam logic [CW-1:0] HOLD_A_C     = CW'(HOLD_A);
    localparam logic [CW-1:0] HOLD_B_C     = CW'(HOLD_B);
    localparam logic [CW-1:0] PULSE_LAST   = CW'(PULSE_TICKS - 1);
    localparam logic [CW-1:0] START_LAST   = CW'(START_TICKS - 1);

    hrc_state_e    state;
    logic [CW-1:0] cnt;
    logic          sel_q;
    logic          all_low;
    logic [CW-1:0] hold_lim;

    assign all_low  = ~|btn_s;
    assign hold_lim = sel_q ? HOLD_B_C : HOLD_A_C;

    // Phase sequencing, shared tick counter, select capture and request register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_BOOT;
            cnt   <= '0;
            sel_q <= 1'b0;
            req_n <= 1'b1;
        end else begin
            case (state)
                ST_BOOT: begin
                    sel_q <= sel_s;
                    if (tick) begin
                        if (cnt == START_LAST) begin
                            state <= ST_ARMED;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_ARMED: begin
                    if (!all_low) begin
                        cnt   <= '0;
                        sel_q <= sel_s;
                    end else if (cnt >= hold_lim) begin
                        state <= ST_FIRE;
                        cnt   <= '0;
                        req_n <= 1'b0;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_FIRE: begin
                    if (LEVEL_MODE != 0) begin
                        if (!all_low) begin
                            state <= ST_ARMED;
                            req_n <= 1'b1;
                            sel_q <= sel_s;
                        end
                    end else if (tick) begin
                        if (cnt == PULSE_LAST) begin
                            state <= ST_WAIT;
                            cnt   <= '0;
                            req_n <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    if (!all_low) begin
                        state <= ST_ARMED;
                        cnt   <= '0;
                        sel_q <= sel_s;
                    end
                end
            endcase
        end
    end

    a_r1_fire_needs_all_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_n) |-> $past(all_low));

    a_r4_sel_frozen_while_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(all_low) && ($past(state) != ST_BOOT)) |-> $stable(sel_q));

    a_r7_no_request_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_WAIT) |-> req_n);

    a_r10_quiet_in_startup: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BOOT) |-> req_n);

    generate
        if (LEVEL_MODE != 0) begin : g_lvl_chk
            a_r6_level_release: assert property (@(posedge clk) disable iff (!rst_n)
                (!req_n && !all_low) |=> req_n);
        end else begin : g_pulse_chk
            a_r5_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
                (state == ST_FIRE) |-> (cnt <= PULSE_LAST));
        end
    endgenerate

endmodule

// File: rtl/hold_reset_ctrl.sv
// Top of the long-press reset controller: synchronises the buttons and the select,
// runs the tick prescaler, and drives the active-low reset request.
// Assumes: a single clock; rst_n is synchronous; the output drives an on-chip reset tree.
module hold_reset_ctrl #(
    parameter int NUM_BTN      = 2,
    parameter int TICK_DIV     = 50000,
    parameter int HOLD_A_TICKS = 7500,
    parameter int HOLD_B_TICKS = 12500,
    parameter int PULSE_TICKS  = 400,
    parameter int START_TICKS  = 1,
    parameter int LEVEL_MODE   = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BTN-1:0] btn_n,
    input  logic               dly_sel,
    output logic               rst_req_n
);

    localparam int CNT_MAX = hrc_pkg::max4(HOLD_A_TICKS, HOLD_B_TICKS, PULSE_TICKS, START_TICKS);
    localparam int CW      = $clog2(CNT_MAX + 1) < 1 ? 1 : $clog2(CNT_MAX + 1);
    localparam logic [NUM_BTN:0] SYNC_IDLE = {1'b0, {NUM_BTN{1'b1}}};

    logic [NUM_BTN:0]   sync_q;
    logic               tick;

    hrc_sync #(
        .W       (NUM_BTN + 1),
        .RST_VAL (SYNC_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({dly_sel, btn_n}),
        .q_sync  (sync_q)
    );

    hrc_tick #(
        .DIV (TICK_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    hrc_ctrl #(
        .NUM_BTN     (NUM_BTN),
        .HOLD_A      (HOLD_A_TICKS),
        .HOLD_B      (HOLD_B_TICKS),
        .PULSE_TICKS (PULSE_TICKS),
        .START_TICKS (START_TICKS),
        .LEVEL_MODE  (LEVEL_MODE),
        .CW          (CW)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .btn_s (sync_q[NUM_BTN-1:0]),
        .sel_s (sync_q[NUM_BTN]),
        .req_n (rst_req_n)
    );

endmodule

// File: tb/test_hold_reset_ctrl.sv
// Bench: a pulse-mode instance and a level-mode instance share stimulus.
module test_hold_reset_ctrl;

    localparam int P  = 4;
    localparam int HA = 10;
    localparam int HB = 20;
    localparam int PT = 8;
    localparam int ST = 6;

    // Table entry: {press clocks[7:0], select, request expected}
    localparam logic [9:0] TBL [6] = '{
        {8'd20,  1'b0, 1'b0},
        {8'd36,  1'b0, 1'b0},
        {8'd60,  1'b0, 1'b1},
        {8'd60,  1'b1, 1'b0},
        {8'd100, 1'b1, 1'b1},
        {8'd3,   1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] btn_n;
    logic       sel;
    logic       rq_p, rq_l;

    int n_chk = 0;
    int n_err = 0;
    int falls_p = 0;
    logic prev_p = 1'b1;
    logic seen_p = 1'b0;
    logic seen_l = 1'b0;

    always #10 clk = ~clk;

    hold_reset_ctrl #(
        .NUM_BTN(2), .TICK_DIV(P), .HOLD_A_TICKS(HA), .HOLD_B_TICKS(HB),
        .PULSE_TICKS(PT), .START_TICKS(ST), .LEVEL_MODE(0)
    ) i_hold_reset_ctrl (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .dly_sel(sel), .rst_req_n(rq_p)
    );

    hold_reset_ctrl #(
        .NUM_BTN(2), .TICK_DIV(P), .HOLD_A_TICKS(HA), .HOLD_B_TICKS(0),
        .PULSE_TICKS(PT), .START_TICKS(ST), .LEVEL_MODE(1)
    ) i_hold_reset_ctrl_lvl (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .dly_sel(sel), .rst_req_n(rq_l)
    );

    // Output monitor, sampled after each rising edge has settled.
    always @(posedge clk) begin
        #2;
        if (prev_p && !rq_p) falls_p++;
        prev_p = rq_p;
        if (!rq_p) seen_p = 1'b1;
        if (!rq_l) seen_l = 1'b1;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_fall(input bit lvl, input int maxc, output int c);
        c = 0;
        while ((lvl ? rq_l : rq_p) && c < maxc) begin
            cyc(1);
            c++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int c, d, f0;
        rst_n = 1'b0;
        btn_n = 2'b00;
        sel   = 1'b0;
        cyc(5);
        // R10: request high during power-on reset
        chk(rq_p && rq_l, "R10", "high during reset", {rq_p, rq_l}, 3);
        rst_n = 1'b1;
        wait_fall(1'b0, 300, c);
        chk(c >= (ST + HA - 2) * P && c <= (ST + HA) * P + 6, "R10",
            "held at power-up, clocks to request", c, (ST + HA) * P);
        btn_n = 2'b11;
        cyc(60);
        chk(rq_p && rq_l, "R10", "idle after start-up", {rq_p, rq_l}, 3);

        // R1 R3: table of press lengths against the selected hold
        foreach (TBL[i]) begin
            sel = TBL[i][1];
            cyc(10);
            seen_p = 1'b0;
            btn_n = 2'b00;
            cyc(int'(TBL[i][9:2]));
            btn_n = 2'b11;
            cyc(4);
            chk(seen_p == TBL[i][0], "R1 R3", "table request seen", seen_p, TBL[i][0]);
            cyc(60);
        end

        // R2: a brief release restarts the hold measurement
        sel = 1'b0;
        cyc(10);
        btn_n = 2'b00;
        cyc(30);
        btn_n = 2'b01;
        cyc(3);
        btn_n = 2'b00;
        wait_fall(1'b0, 120, c);
        chk(c >= (HA - 1) * P && c <= HA * P + 6, "R2", "clocks from re-press", c, HA * P);
        btn_n = 2'b11;
        cyc(60);

        // R1 R5 R6 R7: one long press
        f0 = falls_p;
        btn_n = 2'b00;
        wait_fall(1'b0, 120, c);
        chk(c >= (HA - 1) * P && c <= HA * P + 6, "R1", "clocks to request", c, HA * P);
        d = 0;
        while (!rq_p && d < 200) begin
            cyc(1);
            d++;
        end
        chk(d >= (PT - 1) * P && d <= PT * P + 2, "R5", "pulse length", d, PT * P);
        cyc(100);
        chk(falls_p - f0 == 1, "R7", "requests per press", falls_p - f0, 1);
        chk(rq_l == 1'b0, "R6", "level request while held", rq_l, 0);
        btn_n = 2'b11;
        cyc(5);
        chk(rq_l == 1'b1, "R6", "level request after release", rq_l, 1);
        cyc(60);

        // R9: zero hold on the level instance
        sel = 1'b1;
        cyc(10);
        btn_n = 2'b00;
        cyc(5);
        chk(rq_l == 1'b0, "R9", "zero-hold request", rq_l, 0);
        btn_n = 2'b11;
        cyc(60);
        sel = 1'b0;
        cyc(10);

        // R4: select change while held is ignored
        btn_n = 2'b00;
        cyc(6);
        sel = 1'b1;
        cyc(14);
        chk(rq_l == 1'b1, "R4", "level instance kept old hold", rq_l, 1);
        wait_fall(1'b0, 100, c);
        c += 20;
        chk(c <= HA * P + 6, "R4", "pulse instance clocks to request", c, HA * P);
        btn_n = 2'b11;
        sel = 1'b0;
        cyc(60);

        // R5 R7: glitch during the pulse is masked
        f0 = falls_p;
        btn_n = 2'b00;
        wait_fall(1'b0, 120, c);
        cyc(8);
        btn_n = 2'b01;
        cyc(2);
        btn_n = 2'b00;
        cyc(PT * P + 100);
        chk(falls_p - f0 == 1, "R5", "requests after glitch", falls_p - f0, 1);
        chk(rq_p == 1'b1, "R7", "no request while still held", rq_p, 1);
        btn_n = 2'b11;
        cyc(60);

        // R8: release during the pulse re-arms after it ends
        f0 = falls_p;
        btn_n = 2'b00;
        wait_fall(1'b0, 120, c);
        cyc(8);
        btn_n = 2'b11;
        cyc(4);
        chk(rq_p == 1'b0, "R5", "pulse ignores release", rq_p, 0);
        d = 0;
        while (!rq_p && d < 200) begin
            cyc(1);
            d++;
        end
        cyc(10);
        btn_n = 2'b00;
        wait_fall(1'b0, 120, c);
        chk(c <= HA * P + 6 && falls_p - f0 == 2, "R8", "re-armed request",
            falls_p - f0, 2);
        btn_n = 2'b11;
        cyc(60);

        // R11: a single held button is not enough
        seen_p = 1'b0;
        seen_l = 1'b0;
        btn_n = 2'b10;
        cyc(100);
        chk(!seen_p && !seen_l, "R11", "one button held", {seen_p, seen_l}, 0);
        btn_n = 2'b11;
        cyc(10);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule